// File: doc/BRIEF.md
# Multiprocessor-Capable UART Receiver

This block is the receive half of an asynchronous serial port. It watches a serial line through a clock enable that pulses sixteen times per bit period. It checks each start bit at mid-bit and then samples every later bit at its centre. The frame shape comes from three format inputs: 7 or 8 data bits, an optional even parity bit, and 1 or 2 stop bits. Data arrives least significant bit first. Each accepted frame is loaded into a holding byte and raises a full flag. Sticky overrun, framing, parity and break flags record problems until software clears them all at once with one strobe.

In multiprocessor mode the frame carries one extra bit after the data and before the stop bits, and parity is not used. The value of that bit from the most recent frame can always be read. A filter enable, written through its own strobe, makes the receiver ignore frames whose extra bit is 0. Such frames leave the data byte, the full flag and the error flags untouched, so a node can sleep through traffic meant for other stations until an address frame arrives.

Top module: `mpuart_rx`

## Requirements
- R1: Data bits are received LSB first. With fmt_8bit=1 the frame has 8 data bits. With fmt_8bit=0 it has 7, and rx_data[7] reads 0. fmt_2stop=1 adds a second stop bit. A completed frame that is accepted loads rx_data and sets rx_full.
- R2: A low level on rx_line that is gone by the middle of the start bit (a glitch shorter than half a bit) starts no frame and changes no output.
- R3: With fmt_parity=1 and mp_mode=0, a parity bit follows the data bits. err_parity is set when the data bits and the parity bit together hold an odd number of ones (even parity).
- R4: err_framing is set when the first stop bit samples 0. err_break is set when every data, parity or multiprocessor bit and the first stop bit all sample 0.
- R5: When a frame is accepted while rx_full is 1 and data_rd is not pulsed in that cycle, err_overrun is set. The new frame is dropped: rx_data keeps the old byte and the dropped frame's other error conditions are not recorded.
- R6: A data_rd pulse clears rx_full.
- R7: An err_clr pulse clears err_overrun, err_framing, err_parity and err_break together. It wins over a flag being set in the same cycle.
- R8: With mp_mode=1 the bit after the data bits is the multiprocessor bit, fmt_parity is ignored, and mp_bit_last takes that bit's value at the end of every frame, whether or not the frame is accepted.
- R9: With the filter enabled and mp_mode=1, a frame whose multiprocessor bit is 0 leaves rx_data, rx_full and all four error flags unchanged. A frame whose bit is 1 is accepted.
- R10: With the filter disabled, every frame is accepted, whatever its multiprocessor bit.
- R11: Reset clears rx_data, rx_full, the error flags, mp_bit_last and the filter enable. A pulse on mpf_we loads the filter enable from mpf_wdata.
- R12: Driving rx_en to 0 abandons a frame in progress. Nothing from it reaches the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Enable pulsing 16 times per bit period |
| rx_line | input | 1 | Serial input, idle high |
| rx_en | input | 1 | Receiver enable |
| fmt_8bit | input | 1 | 1: 8 data bits, 0: 7 data bits |
| fmt_parity | input | 1 | Even parity bit present (ignored when mp_mode=1) |
| fmt_2stop | input | 1 | 1: two stop bits, 0: one |
| mp_mode | input | 1 | Frame carries a multiprocessor bit |
| mpf_we | input | 1 | Write strobe for the filter enable |
| mpf_wdata | input | 1 | Value loaded into the filter enable |
| data_rd | input | 1 | Read strobe, clears rx_full |
| err_clr | input | 1 | Clears all four error flags |
| rx_data | output | 8 | Received byte |
| rx_full | output | 1 | Received byte waiting to be read |
| err_overrun | output | 1 | Frame lost because the byte was unread |
| err_framing | output | 1 | First stop bit was low |
| err_parity | output | 1 | Even parity mismatch |
| err_break | output | 1 | Whole frame was low |
| mp_bit_last | output | 1 | Multiprocessor bit of the latest frame |

## Verification
The hardest case to reach is a rejected frame that would otherwise raise error flags. The bench first enables the filter. It then sends a frame with its multiprocessor bit at 0 and its stop bit pulled low, and checks that the framing flag, the data byte and the full flag all stay unchanged while mp_bit_last still follows the frame. Break frames need a line that stays low through the stop bit and is then released before the next start check, so the bench drops the stop bit only for its first part. Abandonment is reached by clearing rx_en partway through the data bits and then sending the rest of the frame.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;

  localparam int unsigned MAX_FRAME_BITS = 11;

  // number of bits after the start bit for a given format
  function automatic logic [3:0] frame_len(input logic d8, input logic par,
                                           input logic two, input logic mp);
    int n;
    n = d8 ? 8 : 7;
    if (mp || par) n = n + 1;
    n = n + (two ? 2 : 1);
    return 4'(n);
  endfunction

  // position of the first stop bit after the start bit
  function automatic logic [3:0] stop_pos(input logic d8, input logic par,
                                          input logic mp);
    int n;
    n = d8 ? 8 : 7;
    if (mp || par) n = n + 1;
    return 4'(n);
  endfunction

  // 1 when data plus parity bit hold an odd count of ones
  function automatic logic even_fail(input logic [7:0] d, input logic p);
    return ^{d, p};
  endfunction
endpackage

// File: rtl/mpuart_rx_sampler.sv
module mpuart_rx_sampler #(
  parameter int unsigned OSR  = 16,
  parameter int unsigned MAXB = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            rx_in,
  input  logic            enable,
  input  logic [3:0]      nbits,
  output logic [MAXB-1:0] bits,
  output logic            done
);
  import mpuart_pkg::*;
  localparam int unsigned CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic            rx_s1, rx_s2;
  rx_state_e       st;
  logic [CW-1:0]   cnt;
  logic [3:0]      idx;
  logic            sample_now;

  assign sample_now = tick && (st == RX_BITS) && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
    end else begin
      rx_s1 <= rx_in;
      rx_s2 <= rx_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= RX_IDLE;
      cnt  <= '0;
      idx  <= '0;
      bits <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!enable) begin
        st  <= RX_IDLE;
        cnt <= '0;
        idx <= '0;
      end else if (tick) begin
        unique case (st)
          RX_IDLE: begin
            if (!rx_s2) begin
              st  <= RX_START;
              cnt <= '0;
            end
          end
          RX_START: begin
            if (cnt == MID) begin
              cnt <= '0;
              idx <= '0;
              st  <= rx_s2 ? RX_IDLE : RX_BITS;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_BITS: begin
            if (sample_now) begin
              bits[idx] <= rx_s2;
              cnt       <= '0;
              if (idx == nbits - 4'd1) begin
                st   <= RX_IDLE;
                done <= 1'b1;
              end
              idx <= idx + 4'd1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  // R1: a frame completes in a single-cycle event
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R12: a disabled receiver completes nothing
  a_r12_abandon: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !done);
  // R2: a frame can only complete from the bit-sampling state
  a_r2_from_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(st) == RX_BITS);
endmodule

// File: rtl/mpuart_rx_decode.sv
module mpuart_rx_decode #(
  parameter int unsigned MAXB = 11
) (
  input  logic [MAXB-1:0] bits,
  input  logic            d8,
  input  logic            par_en,
  input  logic            mp,
  output logic [7:0]      data,
  output logic            mpb,
  output logic            fe,
  output logic            pe,
  output logic            brk
);
  import mpuart_pkg::*;
  logic [3:0] spos;
  logic       xbit;
  logic       any_high;

  assign spos = stop_pos(d8, par_en, mp);
  assign data = d8 ? bits[7:0] : {1'b0, bits[6:0]};
  assign xbit = d8 ? bits[8] : bits[7];
  assign mpb  = mp ? xbit : 1'b0;
  assign fe   = !bits[spos];
  assign pe   = par_en && !mp && even_fail(data, xbit);

  always_comb begin
    any_high = 1'b0;
    for (int i = 0; i < int'(MAXB); i++) begin
      if (i <= int'(spos)) any_high = any_high | bits[i];
    end
  end
  assign brk = !any_high;
endmodule

// File: rtl/mpuart_rx_status.sv
module mpuart_rx_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done,
  input  logic [7:0] dec_data,
  input  logic       dec_mpb,
  input  logic       dec_fe,
  input  logic       dec_pe,
  input  logic       dec_brk,
  input  logic       mp_mode,
  input  logic       data_rd,
  input  logic       err_clr,
  input  logic       mpf_we,
  input  logic       mpf_wdata,
  output logic [7:0] rx_data,
  output logic       rx_full,
  output logic       ovrn,
  output logic       fe,
  output logic       pe,
  output logic       brk,
  output logic       mpb_last
);
  logic filt;
  logic accept;
  logic room;

  assign accept = !(filt && mp_mode) || dec_mpb;
  assign room   = !rx_full || data_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt     <= 1'b0;
      rx_data  <= '0;
      rx_full  <= 1'b0;
      ovrn     <= 1'b0;
      fe       <= 1'b0;
      pe       <= 1'b0;
      brk      <= 1'b0;
      mpb_last <= 1'b0;
    end else begin
      if (mpf_we) filt <= mpf_wdata;
      if (data_rd) rx_full <= 1'b0;
      if (done && mp_mode) mpb_last <= dec_mpb;
      if (done && accept) begin
        if (room) begin
          rx_data <= dec_data;
          rx_full <= 1'b1;
          fe      <= fe  | dec_fe;
          pe      <= pe  | dec_pe;
          brk     <= brk | dec_brk;
        end else begin
          ovrn <= 1'b1;
        end
      end
      if (err_clr) begin
        ovrn <= 1'b0;
        fe   <= 1'b0;
        pe   <= 1'b0;
        brk  <= 1'b0;
      end
    end
  end

  // R7: clear strobe empties every error flag
  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> !ovrn && !fe && !pe && !brk);
  // R9: a filtered frame touches nothing
  a_r9_filter_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && filt && mp_mode && !dec_mpb && !data_rd && !err_clr) |=>
      $stable(rx_data) && $stable(rx_full) && $stable(fe) && $stable(pe)
      && $stable(brk) && $stable(ovrn));
  // R5: overrun keeps the old byte
  a_r5_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    (done && accept && rx_full && !data_rd && !err_clr) |=>
      $stable(rx_data) && ovrn);
  // R6: read empties the holding byte unless a frame lands
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !done) |=> !rx_full);
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
  parameter int unsigned OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rx_line,
  input  logic       rx_en,
  input  logic       fmt_8bit,
  input  logic       fmt_parity,
  input  logic       fmt_2stop,
  input  logic       mp_mode,
  input  logic       mpf_we,
  input  logic       mpf_wdata,
  input  logic       data_rd,
  input  logic       err_clr,
  output logic [7:0] rx_data,
  output logic       rx_full,
  output logic       err_overrun,
  output logic       err_framing,
  output logic       err_parity,
  output logic       err_break,
  output logic       mp_bit_last
);
  import mpuart_pkg::*;
  localparam int unsigned MAXB = MAX_FRAME_BITS;

  logic [MAXB-1:0] frame_bits;
  logic            frame_done;
  logic [3:0]      nbits;
  logic [7:0]      dec_data;
  logic            dec_mpb, dec_fe, dec_pe, dec_brk;

  assign nbits = frame_len(fmt_8bit, fmt_parity, fmt_2stop, mp_mode);

  mpuart_rx_sampler #(.OSR(OSR), .MAXB(MAXB)) u_sampler (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx_in(rx_line),
    .enable(rx_en), .nbits(nbits), .bits(frame_bits), .done(frame_done)
  );

  mpuart_rx_decode #(.MAXB(MAXB)) u_decode (
    .bits(frame_bits), .d8(fmt_8bit), .par_en(fmt_parity), .mp(mp_mode),
    .data(dec_data), .mpb(dec_mpb), .fe(dec_fe), .pe(dec_pe), .brk(dec_brk)
  );

  mpuart_rx_status u_status (
    .clk(clk), .rst_n(rst_n), .done(frame_done), .dec_data(dec_data),
    .dec_mpb(dec_mpb), .dec_fe(dec_fe), .dec_pe(dec_pe), .dec_brk(dec_brk),
    .mp_mode(mp_mode), .data_rd(data_rd), .err_clr(err_clr),
    .mpf_we(mpf_we), .mpf_wdata(mpf_wdata), .rx_data(rx_data),
    .rx_full(rx_full), .ovrn(err_overrun), .fe(err_framing), .pe(err_parity),
    .brk(err_break), .mpb_last(mp_bit_last)
  );

  // R1: a 7-bit byte never shows bit 7
  a_r1_seven_bit: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_full) && !fmt_8bit) |-> !rx_data[7]);
  // R4: break implies a framing error on the same frame
  a_r4_break_fe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_break) |-> err_framing);
  // R8: mp_bit_last moves only at the end of a frame
  a_r8_mpb_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(mp_bit_last));
endmodule

// File: tb/mpuart_rx_bench.sv
module mpuart_rx_bench;
  localparam int TICKDIV = 4;
  localparam int BITCLK  = 16 * TICKDIV;

  typedef struct {
    logic [7:0] data;
    logic       full, ovr, fe, pe, brk, mpb;
    string      tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0, rx_line = 1'b1;
  logic rx_en = 1'b1, fmt_8bit = 1'b1, fmt_parity = 1'b0, fmt_2stop = 1'b0;
  logic mp_mode = 1'b0, mpf_we = 1'b0, mpf_wdata = 1'b0;
  logic data_rd = 1'b0, err_clr = 1'b0;
  logic [7:0] rx_data;
  logic rx_full, err_overrun, err_framing, err_parity, err_break, mp_bit_last;

  int checks = 0, errors = 0;
  bit done_flag = 0;
  exp_t q[$];
  exp_t m;  // model state
  logic filt_m = 1'b0;

  always #2 clk = ~clk;

  int tdiv = 0;
  always @(posedge clk) begin
    tdiv    <= (tdiv == TICKDIV - 1) ? 0 : tdiv + 1;
    os_tick <= (tdiv == TICKDIV - 1);
  end

  mpuart_rx u_mpuart_rx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
    .rx_en(rx_en), .fmt_8bit(fmt_8bit), .fmt_parity(fmt_parity),
    .fmt_2stop(fmt_2stop), .mp_mode(mp_mode), .mpf_we(mpf_we),
    .mpf_wdata(mpf_wdata), .data_rd(data_rd), .err_clr(err_clr),
    .rx_data(rx_data), .rx_full(rx_full), .err_overrun(err_overrun),
    .err_framing(err_framing), .err_parity(err_parity),
    .err_break(err_break), .mp_bit_last(mp_bit_last)
  );

  // monitor: pop expectations and compare against the ports
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (rx_data !== e.data || rx_full !== e.full || err_overrun !== e.ovr ||
            err_framing !== e.fe || err_parity !== e.pe || err_break !== e.brk ||
            mp_bit_last !== e.mpb) begin
          errors++;
          $display("FAIL %s: got data=%h full=%b ovr=%b fe=%b pe=%b brk=%b mpb=%b, expected data=%h full=%b ovr=%b fe=%b pe=%b brk=%b mpb=%b",
            e.tag, rx_data, rx_full, err_overrun, err_framing, err_parity,
            err_break, mp_bit_last, e.data, e.full, e.ovr, e.fe, e.pe,
            e.brk, e.mpb);
        end
      end
    end
  end

  task automatic push(input string tag);
    repeat (6) @(negedge clk);
    m.tag = tag;
    q.push_back(m);
    repeat (2) @(negedge clk);
  endtask

  task automatic drive_bit(input logic v);
    @(negedge clk) rx_line = v;
    repeat (BITCLK - 1) @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(negedge clk) data_rd = 1'b1;
    @(negedge clk) data_rd = 1'b0;
    m.full = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
    m.ovr = 0; m.fe = 0; m.pe = 0; m.brk = 0;
  endtask

  task automatic set_filter(input logic v);
    @(negedge clk) begin mpf_we = 1'b1; mpf_wdata = v; end
    @(negedge clk) mpf_we = 1'b0;
    filt_m = v;
  endtask

  // driver: send a frame and update the expected state
  task automatic send(input logic [7:0] d, input logic mpb,
                      input logic stop_low, input logic bad_par);
    int nd;
    logic [7:0] dm;
    logic pbit, xbit, accept, brk;
    nd = fmt_8bit ? 8 : 7;
    dm = fmt_8bit ? d : {1'b0, d[6:0]};
    pbit = (^dm) ^ bad_par;
    drive_bit(1'b0);
    for (int i = 0; i < nd; i++) drive_bit(d[i]);
    xbit = 1'b1;
    if (mp_mode) begin drive_bit(mpb); xbit = mpb; end
    else if (fmt_parity) begin drive_bit(pbit); xbit = pbit; end
    if (stop_low) begin
      @(negedge clk) rx_line = 1'b0;
      repeat (40) @(negedge clk);
      rx_line = 1'b1;
      repeat (BITCLK - 41) @(negedge clk);
    end else begin
      drive_bit(1'b1);
    end
    if (fmt_2stop) drive_bit(1'b1);
    // model
    brk = (dm == 8'h00) && stop_low && (!(mp_mode || fmt_parity) || !xbit);
    accept = !(filt_m && mp_mode) || mpb;
    if (mp_mode) m.mpb = mpb;
    if (accept) begin
      if (!m.full) begin
        m.data = dm;
        m.full = 1'b1;
        m.fe  = m.fe | stop_low;
        m.pe  = m.pe | (fmt_parity && !mp_mode && bad_par);
        m.brk = m.brk | brk;
      end else begin
        m.ovr = 1'b1;
      end
    end
  endtask

  initial begin
    m = '{data: 8'h00, full: 0, ovr: 0, fe: 0, pe: 0, brk: 0, mpb: 0, tag: ""};
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    push("R11 reset state");

    send(8'hA5, 0, 0, 0);      push("R1 8N1 byte");
    pulse_rd();                push("R6 read clears full");

    fmt_8bit = 0; fmt_2stop = 1;
    send(8'hC3, 0, 0, 0);      push("R1 7N2 bit7 reads 0");
    pulse_rd();
    fmt_8bit = 1; fmt_2stop = 0; fmt_parity = 1;
    send(8'h3C, 0, 0, 0);      push("R3 good even parity");
    pulse_rd();
    send(8'h3C, 0, 0, 1);      push("R3 parity error");
    pulse_clr(); pulse_rd();   push("R7 clear after parity");
    fmt_parity = 0;

    send(8'h55, 0, 1, 0);      push("R4 framing error");
    pulse_clr(); pulse_rd();
    send(8'h00, 0, 1, 0);      push("R4 break");
    pulse_clr(); pulse_rd();   push("R7 clear after break");

    send(8'h11, 0, 0, 0);
    send(8'h22, 0, 0, 0);      push("R5 overrun keeps old");
    pulse_rd(); pulse_clr();

    @(negedge clk) rx_line = 1'b0;
    repeat (20) @(negedge clk);
    rx_line = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    push("R2 glitch ignored");

    mp_mode = 1;
    send(8'h77, 0, 0, 0);      push("R10 R11 filter off after reset");
    pulse_rd();
    set_filter(1'b1);
    send(8'h88, 0, 1, 0);      push("R9 filtered frame ignored");
    send(8'h99, 1, 0, 0);      push("R8 address frame accepted");
    pulse_rd();
    send(8'h44, 0, 0, 0);      push("R8 mpb follows rejected frame");
    fmt_parity = 1;
    send(8'h01, 1, 0, 0);      push("R8 parity ignored in mp mode");
    pulse_rd();
    fmt_parity = 0;
    set_filter(1'b0);
    send(8'h5A, 0, 0, 0);      push("R10 filter off accepts mpb 0");
    pulse_rd();
    mp_mode = 0;

    // R12: abandon mid-frame
    drive_bit(1'b0);
    drive_bit(1'b1); drive_bit(1'b0); drive_bit(1'b1);
    @(negedge clk) rx_en = 1'b0;
    for (int i = 0; i < 6; i++) drive_bit(1'b0);
    drive_bit(1'b1);
    repeat (BITCLK) @(negedge clk);
    rx_en = 1'b1;
    push("R12 abandoned frame");
    send(8'h6E, 0, 0, 0);      push("R12 receives after re-enable");

    repeat (20) @(negedge clk);
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule